// File: doc/BRIEF.md
# Clockless LED Bit Encoder

This block turns a stream of RGB pixels into the waveform that a chain of single-wire, clockless LEDs expects on its data pin. Each data bit takes one fixed-length bit period. The period is built from three programmable phase lengths, counted in ticks of the block clock. A zero bit stays active for the first phase only. A one bit stays active for the first two phases. The last phase is always spent at the idle level.

A client starts a frame by pulsing a request with a pixel count while the block is not busy. The block then pulls exactly that many pixels through a valid/ready handshake. Each pixel is three 8-bit channel bytes. Each byte goes out most significant bit first, followed by an optional number of zero pad bits. A one-pixel holding register lets the next pixel be taken while the current one is still on the wire, so consecutive bit periods run back to back.

When the last bit period ends, the block pulses a done flag. It then keeps the line at idle for a latch interval, which is given in microseconds and converted to clock ticks at elaboration. A frame whose count is zero or above the maximum is refused with a reject pulse. The output can be inverted for boards that drive the LEDs through an inverting buffer.

Top module: `led_clockless_enc`

## Requirements
- R1: While pixels arrive in time, consecutive rising edges of the active level on `dout` are exactly T1+T2+T3 clock cycles apart.
- R2: A zero bit holds the active level for T1 cycles. A one bit holds it for T1+T2 cycles.
- R3: A pixel is sent as three channels. The first channel is `pix_data[23:16]`, then `[15:8]`, then `[7:0]`. Each channel is sent bit 7 down to bit 0.
- R4: After each 8-bit channel, PAD_BITS extra bits are sent, each encoded as a zero bit. A pixel is therefore (8+PAD_BITS)×3 bit periods.
- R5: With INVERT=0 the line idles low and pulses high. With INVERT=1 the line idles high and pulses low, with unchanged timing.
- R6: `frm_done` is high for one cycle when the last bit period of a frame completes. `busy` then stays high for at least LATCH_TICKS = CLK_HZ×LATCH_US/10^6 cycles. A frame request made during that time is ignored.
- R7: After reset, `busy` stays high for at least LATCH_TICKS cycles. A frame request made during that time is ignored.
- R8: A frame request while idle with `frm_len` of 0 or above MAX_PIXELS produces a one-cycle `frm_reject` pulse. Nothing is sent and `busy` stays low. A count equal to MAX_PIXELS is accepted.
- R9: An accepted frame takes exactly `frm_len` pixels. `pix_ready` is low once that many have been taken.
- R10: If the next pixel has not arrived when a pixel ends, the line holds the idle level until it arrives. Transmission then resumes with correct bits.
- R11: During and right after reset, `dout` is at the idle level, `busy` is 1, and `pix_ready`, `frm_done` and `frm_reject` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (CLK_HZ) |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Frame request, sampled while idle |
| frm_len | input | LEN_W | Pixel count of the requested frame |
| pix_valid | input | 1 | Pixel data valid |
| pix_data | input | 24 | Pixel: first channel in [23:16], third in [7:0] |
| pix_ready | output | 1 | Block takes a pixel this cycle when valid |
| dout | output | 1 | Serial LED data line |
| busy | output | 1 | Frame in progress or latch interval running |
| frm_done | output | 1 | One-cycle pulse at the end of the last bit period |
| frm_reject | output | 1 | One-cycle pulse for a refused frame request |

## Verification
Most internal faults show up as pulses on `dout` with the wrong length, and they do so within one bit period. A wrong phase count shows as a high time that matches neither T1 nor T1+T2, or as a rising-edge spacing other than T1+T2+T3. A bad bit counter or shift register leaves high times that are legal but decode to the wrong bit order, a missing pad bit or a wrong bit total by the frame's `frm_done`. A latch counter that is too short shows as `busy` falling earlier than LATCH_TICKS cycles after `frm_done` or after reset. A wrong pixel count shows at once as `pix_ready` staying high, or as a frame that never completes.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

    localparam int CH_PER_PIX = 3;
    localparam int CH_BITS    = 8;
    localparam int PIX_W      = CH_PER_PIX * CH_BITS;

    // Channel order on the wire: c_first leaves the pin first.
    typedef struct packed {
        logic [CH_BITS-1:0] c_first;
        logic [CH_BITS-1:0] c_second;
        logic [CH_BITS-1:0] c_third;
    } pixel_t;

    typedef enum logic [1:0] {
        ST_GUARD = 2'd0,   // latch interval running
        ST_IDLE  = 2'd1,   // ready for a frame request
        ST_LOAD  = 2'd2,   // waiting for a pixel to enter the shifter
        ST_SEND  = 2'd3    // bit periods on the wire
    } seq_state_t;

    // Latch interval in ticks, rounded down, at least one tick.
    function automatic int latch_ticks(input longint hz, input int us);
        longint t;
        t = (hz * longint'(us)) / 64'd1000000;
        if (t < 1) t = 1;
        return int'(t);
    endfunction

endpackage

// File: rtl/led_latch_timer.sv
module led_latch_timer #(
    parameter int TICKS = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic quiet
);
    localparam int TW = $clog2(TICKS + 1);

    logic [TW-1:0] cnt;

    // Reset loads the full interval so the first frame also waits.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= TW'(TICKS);
        end else if (arm) begin
            cnt <= TW'(TICKS);
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign quiet = (cnt == '0);

    AST_ARM_CLEARS_QUIET: assert property (@(posedge clk) disable iff (rst)
        arm |=> !quiet);                                                    // R6

endmodule

// File: rtl/led_bit_shaper.sv
module led_bit_shaper #(
    parameter int T1     = 6,
    parameter int T2     = 6,
    parameter int T3     = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic bit_val,
    output logic bit_end,
    output logic dout
);
    localparam int TOP = T1 + T2 + T3;
    localparam int CW  = $clog2(TOP);
    localparam logic [CW-1:0] LAST_PH = CW'(TOP - 1);
    localparam logic [CW-1:0] HI_ZERO = CW'(T1);
    localparam logic [CW-1:0] HI_ONE  = CW'(T1 + T2);

    logic [CW-1:0] ph_cnt;
    logic          level_d;
    logic          level_q;

    // One phase counter per bit period; held at zero between bits.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_cnt <= '0;
        end else if (ph_cnt == LAST_PH) begin
            ph_cnt <= '0;
        end else begin
            ph_cnt <= ph_cnt + CW'(1);
        end
    end

    assign bit_end = run && (ph_cnt == LAST_PH);

    always_comb begin
        level_d = 1'b0;
        if (run) begin
            level_d = bit_val ? (ph_cnt < HI_ONE) : (ph_cnt < HI_ZERO);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level_d;
    end

    generate
        if (INVERT) begin : g_inv
            assign dout = ~level_q;
        end else begin : g_pass
            assign dout = level_q;
        end
    endgenerate

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        ph_cnt <= LAST_PH);                                                 // R1

endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq import led_enc_pkg::*; #(
    parameter int PAD_BITS   = 0,
    parameter int MAX_PIXELS = 144,
    parameter int LEN_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_start,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             pix_valid,
    input  pixel_t           pix_data,
    output logic             pix_ready,
    input  logic             quiet,
    output logic             arm,
    output logic             run,
    output logic             bit_val,
    input  logic             bit_end,
    output logic             busy,
    output logic             frm_done,
    output logic             frm_reject
);
    localparam int CH_LEN   = CH_BITS + PAD_BITS;
    localparam int PIX_BITS = CH_PER_PIX * CH_LEN;
    localparam int BC_W     = $clog2(PIX_BITS);
    localparam int CNT_W    = $clog2(MAX_PIXELS + 1);

    seq_state_t          state;
    logic [CNT_W-1:0]    len_q;
    logic [CNT_W-1:0]    fetched;
    logic [CNT_W-1:0]    sent;
    pixel_t              nxt;
    logic                nxt_vld;
    logic [PIX_BITS-1:0] shreg;
    logic [PIX_BITS-1:0] expanded;
    logic [BC_W-1:0]     bitcnt;
    logic                len_ok;
    logic                last_bit;
    logic                last_pix;
    logic                take;

    // Place each channel MSB first, followed by its zero pad bits.
    always_comb begin
        expanded = '0;
        for (int ch = 0; ch < CH_PER_PIX; ch++) begin
            for (int b = 0; b < CH_BITS; b++) begin
                expanded[PIX_BITS-1 - ch*CH_LEN - b] = nxt[PIX_W-1 - ch*CH_BITS - b];
            end
        end
    end

    assign len_ok    = (frm_len != '0) && (frm_len <= LEN_W'(MAX_PIXELS));
    assign last_bit  = (bitcnt == BC_W'(PIX_BITS - 1));
    assign last_pix  = (sent == len_q - CNT_W'(1));
    assign pix_ready = ((state == ST_LOAD) || (state == ST_SEND)) && !nxt_vld && (fetched != len_q);
    assign take      = pix_valid && pix_ready;
    assign run       = (state == ST_SEND);
    assign bit_val   = shreg[PIX_BITS-1];
    assign busy      = (state != ST_IDLE);
    assign arm       = run && bit_end && last_bit && last_pix;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_GUARD;
            len_q      <= '0;
            fetched    <= '0;
            sent       <= '0;
            nxt        <= '0;
            nxt_vld    <= 1'b0;
            shreg      <= '0;
            bitcnt     <= '0;
            frm_done   <= 1'b0;
            frm_reject <= 1'b0;
        end else begin
            frm_done   <= 1'b0;
            frm_reject <= 1'b0;
            unique case (state)
                ST_GUARD: begin
                    if (quiet) state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (frm_start) begin
                        if (len_ok) begin
                            len_q   <= frm_len[CNT_W-1:0];
                            fetched <= '0;
                            sent    <= '0;
                            state   <= ST_LOAD;
                        end else begin
                            frm_reject <= 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (nxt_vld) begin
                        shreg   <= expanded;
                        nxt_vld <= 1'b0;
                        bitcnt  <= '0;
                        state   <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (bit_end) begin
                        if (last_bit) begin
                            sent <= sent + CNT_W'(1);
                            if (last_pix) begin
                                state    <= ST_GUARD;
                                frm_done <= 1'b1;
                            end else if (nxt_vld) begin
                                shreg   <= expanded;
                                nxt_vld <= 1'b0;
                                bitcnt  <= '0;
                            end else begin
                                state <= ST_LOAD;
                            end
                        end else begin
                            shreg  <= shreg << 1;
                            bitcnt <= bitcnt + BC_W'(1);
                        end
                    end
                end
                default: state <= ST_GUARD;
            endcase
            // Holding register fill; exclusive with its drain (needs !nxt_vld).
            if (take) begin
                nxt     <= pix_data;
                nxt_vld <= 1'b1;
                fetched <= fetched + CNT_W'(1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        busy && (state != ST_GUARD) |-> fetched <= len_q);                  // R9
    AST_DONE_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        frm_done |-> busy && !quiet);                                       // R6
    AST_GUARD_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(quiet));                                      // R7
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        frm_reject |-> !busy && !pix_ready);                                // R8

endmodule

// File: rtl/led_clockless_enc.sv
module led_clockless_enc import led_enc_pkg::*; #(
    parameter longint CLK_HZ     = 16_000_000,
    parameter int     LATCH_US   = 10,
    parameter int     T1         = 6,
    parameter int     T2         = 6,
    parameter int     T3         = 8,
    parameter int     PAD_BITS   = 0,
    parameter bit     INVERT     = 1'b0,
    parameter int     MAX_PIXELS = 144,
    parameter int     LEN_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_start,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             pix_valid,
    input  logic [23:0]      pix_data,
    output logic             pix_ready,
    output logic             dout,
    output logic             busy,
    output logic             frm_done,
    output logic             frm_reject
);
    localparam int LATCH_TICKS = latch_ticks(CLK_HZ, LATCH_US);

    logic   quiet;
    logic   arm;
    logic   run;
    logic   bit_val;
    logic   bit_end;
    pixel_t pix_s;

    assign pix_s = pixel_t'(pix_data);

    led_frame_seq #(
        .PAD_BITS   (PAD_BITS),
        .MAX_PIXELS (MAX_PIXELS),
        .LEN_W      (LEN_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .frm_start  (frm_start),
        .frm_len    (frm_len),
        .pix_valid  (pix_valid),
        .pix_data   (pix_s),
        .pix_ready  (pix_ready),
        .quiet      (quiet),
        .arm        (arm),
        .run        (run),
        .bit_val    (bit_val),
        .bit_end    (bit_end),
        .busy       (busy),
        .frm_done   (frm_done),
        .frm_reject (frm_reject)
    );

    led_bit_shaper #(
        .T1     (T1),
        .T2     (T2),
        .T3     (T3),
        .INVERT (INVERT)
    ) shp_i (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .bit_val (bit_val),
        .bit_end (bit_end),
        .dout    (dout)
    );

    led_latch_timer #(
        .TICKS (LATCH_TICKS)
    ) tmr_i (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm),
        .quiet (quiet)
    );

    AST_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> dout == INVERT);                                          // R5

endmodule

// File: tb/led_clockless_enc_tb_top.sv
module led_pulse_mon #(
    parameter int T1  = 6,
    parameter int T2  = 6,
    parameter int T3  = 8,
    parameter bit INV = 1'b0
) (
    input logic clk,
    input logic clr,
    input logic dout
);
    localparam int TOP = T1 + T2 + T3;
    bit bits [0:1023];
    int nbits, ones, bad_hi, bad_period, hi_len, rise_gap;
    bit prev_act, seen_rise;

    initial begin
        nbits = 0; ones = 0; bad_hi = 0; bad_period = 0;
        hi_len = 0; rise_gap = 0; prev_act = 0; seen_rise = 0;
    end

    always @(negedge clk) begin
        bit act;
        act = dout ^ INV;
        if (clr) begin
            nbits = 0; ones = 0; bad_hi = 0; bad_period = 0;
            hi_len = 0; rise_gap = 0; seen_rise = 0;
        end else begin
            if (act && !prev_act) begin
                if (seen_rise && rise_gap != TOP) bad_period++;
                seen_rise = 1;
                rise_gap = 0;
            end
            if (act) hi_len++;
            else if (prev_act) begin
                if (hi_len == T1) begin
                    if (nbits < 1024) bits[nbits] = 0;
                    nbits++;
                end else if (hi_len == T1 + T2) begin
                    if (nbits < 1024) bits[nbits] = 1;
                    nbits++;
                    ones++;
                end else bad_hi++;
                hi_len = 0;
            end
            if (rise_gap < 100000) rise_gap++;
        end
        prev_act = act;
    end
endmodule

module led_clockless_enc_tb_top;
    localparam int TOP1 = 20;
    localparam int LT1  = 160;
    localparam int PAD2 = 2;

    logic clk = 0;
    logic rst = 1;
    always #4 clk = ~clk;

    logic        s1 = 0, v1 = 0, s2 = 0, v2 = 0, clr = 0;
    logic [15:0] len1 = 0, len2 = 0;
    logic [23:0] data1 = 0, data2 = 0;
    logic        rdy1, dout1, busy1, done1, rej1;
    logic        rdy2, dout2, busy2, done2, rej2;

    led_clockless_enc dut_i (
        .clk(clk), .rst(rst), .frm_start(s1), .frm_len(len1), .pix_valid(v1),
        .pix_data(data1), .pix_ready(rdy1), .dout(dout1), .busy(busy1),
        .frm_done(done1), .frm_reject(rej1));

    led_clockless_enc #(.LATCH_US(1), .T1(2), .T2(3), .T3(3), .PAD_BITS(PAD2),
                        .INVERT(1'b1), .MAX_PIXELS(4)) dut2_i (
        .clk(clk), .rst(rst), .frm_start(s2), .frm_len(len2), .pix_valid(v2),
        .pix_data(data2), .pix_ready(rdy2), .dout(dout2), .busy(busy2),
        .frm_done(done2), .frm_reject(rej2));

    led_pulse_mon #(.T1(6), .T2(6), .T3(8), .INV(1'b0)) mon1 (.clk(clk), .clr(clr), .dout(dout1));
    led_pulse_mon #(.T1(2), .T2(3), .T3(3), .INV(1'b1)) mon2 (.clk(clk), .clr(clr), .dout(dout2));

    // Stimulus pixels with the expected count of one bits.
    localparam logic [23:0] VEC_PIX  [0:4] = '{24'h000000, 24'hFFFFFF, 24'hA53C81, 24'h807E01, 24'h5A5A5A};
    localparam int          VEC_ONES [0:4] = '{0, 24, 10, 8, 12};

    int n_tests = 0, n_fail = 0;
    logic [23:0] pq [0:7];
    bit last_rej;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    task automatic start_frame(input int sel, input int n);
        @(negedge clk);
        if (sel == 1) begin s1 = 1; len1 = 16'(n); end
        else          begin s2 = 1; len2 = 16'(n); end
        @(negedge clk);
        s1 = 0; s2 = 0;
        last_rej = (sel == 1) ? rej1 : rej2;
    endtask

    task automatic push_pix(input int sel, input logic [23:0] p);
        if (sel == 1) begin
            v1 = 1; data1 = p;
            while (!rdy1) @(negedge clk);
            @(negedge clk); v1 = 0;
        end else begin
            v2 = 1; data2 = p;
            while (!rdy2) @(negedge clk);
            @(negedge clk); v2 = 0;
        end
    endtask

    task automatic wait_done(input int sel, output int cyc);
        cyc = 0;
        while (!((sel == 1) ? done1 : done2) && cyc < 100000) begin
            @(negedge clk); cyc++;
        end
    endtask

    task automatic wait_idle(input int sel, output int cyc);
        cyc = 0;
        while (((sel == 1) ? busy1 : busy2) && cyc < 100000) begin
            @(negedge clk); cyc++;
        end
    endtask

    function automatic bit exp_bit(input logic [23:0] p, input int pad, input int idx);
        int ch, pos;
        ch  = idx / (8 + pad);
        pos = idx % (8 + pad);
        if (pos >= 8) return 1'b0;
        return p[23 - 8*ch - pos];
    endfunction

    task automatic check_bits(input int sel, input int n, input int pad, input string req);
        int nb, bad, tot;
        tot = n * 3 * (8 + pad);
        nb  = (sel == 1) ? mon1.nbits : mon2.nbits;
        chk(nb == tot, {req, " bit count"}, nb, tot);
        bad = 0;
        for (int i = 0; i < tot && i < nb; i++) begin
            bit got;
            got = (sel == 1) ? mon1.bits[i] : mon2.bits[i];
            if (got != exp_bit(pq[i / (3 * (8 + pad))], pad, i % (3 * (8 + pad)))) bad++;
        end
        chk(bad == 0, {req, " bit values"}, bad, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int cyc;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(dout1 == 0 && busy1 == 1 && rdy1 == 0 && done1 == 0 && rej1 == 0, "R11 reset outputs", {dout1, busy1, rdy1}, 3'b010);
        chk(dout2 == 1, "R5 inverted idle in reset", dout2, 1);
        rst = 0;
        // R7: guard after reset, request during it ignored
        cyc = 0;
        repeat (20) begin @(negedge clk); cyc++; end
        s1 = 1; len1 = 1; @(negedge clk); cyc++; s1 = 0;
        while (busy1 && cyc < 1000) begin @(negedge clk); cyc++; end
        chk(cyc >= LT1 && cyc <= LT1 + 5, "R7 busy after reset", cyc, LT1 + 1);
        repeat (10) @(negedge clk);
        chk(rdy1 == 0 && !busy1 && mon1.nbits == 0, "R7 request in guard ignored", {rdy1, busy1}, 0);

        // R1 R2 R3: vector table of single-pixel frames
        for (int k = 0; k < 5; k++) begin
            clear_mon();
            pq[0] = VEC_PIX[k];
            start_frame(1, 1);
            push_pix(1, VEC_PIX[k]);
            wait_done(1, cyc);
            chk(done1 == 1, "R6 done pulse", done1, 1);
            repeat (3) @(negedge clk);
            check_bits(1, 1, 0, "R3");
            chk(mon1.ones == VEC_ONES[k], "R2 one bits", mon1.ones, VEC_ONES[k]);
            chk(mon1.bad_hi == 0, "R2 high times", mon1.bad_hi, 0);
            chk(mon1.bad_period == 0, "R1 period", mon1.bad_period, 0);
            if (k == 0) begin
                // R6: latch gap, and a request inside it is ignored
                cyc = 3;
                while (busy1 && cyc < 1000) begin
                    @(negedge clk); cyc++;
                    if (cyc == 10) s1 = 1; else s1 = 0;
                end
                s1 = 0;
                chk(cyc >= LT1, "R6 latch gap", cyc, LT1);
                repeat (100) @(negedge clk);
                chk(!busy1 && rdy1 == 0 && mon1.nbits == 24, "R6 request in latch ignored", mon1.nbits, 24);
            end else begin
                wait_idle(1, cyc);
            end
        end

        // R9 R1: three pixels back to back
        clear_mon();
        pq[0] = 24'h123456; pq[1] = 24'hFEDCBA; pq[2] = 24'h0F0F0F;
        start_frame(1, 3);
        for (int i = 0; i < 3; i++) push_pix(1, pq[i]);
        repeat (5) @(negedge clk);
        chk(rdy1 == 0 && busy1, "R9 ready low after last pixel", rdy1, 0);
        wait_done(1, cyc);
        repeat (3) @(negedge clk);
        check_bits(1, 3, 0, "R9");
        chk(mon1.bad_period == 0, "R1 period multi-pixel", mon1.bad_period, 0);
        wait_idle(1, cyc);

        // R10: underrun between two pixels
        clear_mon();
        pq[0] = 24'hC30001; pq[1] = 24'h00FF80;
        start_frame(1, 2);
        push_pix(1, pq[0]);
        repeat (700) @(negedge clk);
        chk(dout1 == 0 && busy1 == 1, "R10 idle during underrun", dout1, 0);
        push_pix(1, pq[1]);
        wait_done(1, cyc);
        repeat (3) @(negedge clk);
        check_bits(1, 2, 0, "R10");
        chk(mon1.bad_period == 1, "R10 one stretched period", mon1.bad_period, 1);
        wait_idle(1, cyc);

        // R8: rejection of bad counts
        clear_mon();
        start_frame(1, 145);
        chk(last_rej == 1, "R8 reject above max", last_rej, 1);
        @(negedge clk);
        chk(rej1 == 0 && busy1 == 0, "R8 reject one cycle, not busy", {rej1, busy1}, 0);
        start_frame(1, 0);
        chk(last_rej == 1, "R8 reject zero", last_rej, 1);
        repeat (50) @(negedge clk);
        chk(mon1.nbits == 0 && rdy1 == 0 && busy1 == 0, "R8 nothing sent", mon1.nbits, 0);

        // R4 R5 R8: padded, inverted instance at its maximum count
        clear_mon();
        pq[0] = 24'h81FF00; pq[1] = 24'h7E0180; pq[2] = 24'h000001; pq[3] = 24'hAAAA55;
        start_frame(2, 5);
        chk(last_rej == 1, "R8 reject above small max", last_rej, 1);
        start_frame(2, 4);
        chk(last_rej == 0 && busy2 == 1, "R8 max count accepted", busy2, 1);
        for (int i = 0; i < 4; i++) push_pix(2, pq[i]);
        wait_done(2, cyc);
        repeat (3) @(negedge clk);
        check_bits(2, 4, PAD2, "R4");
        chk(mon2.bad_hi == 0 && mon2.bad_period == 0, "R5 inverted timing", mon2.bad_hi + mon2.bad_period, 0);
        wait_idle(2, cyc);
        chk(dout2 == 1, "R5 inverted idle high", dout2, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule